// File: doc/BRIEF.md
# Serial Boot-Flash Master with Shared Ring Buffer

This block is a register-driven serial flash master for a boot device on a single chip-select line. Software places the command byte in a dedicated register and the numbers of bytes to send and to collect in a packed count register. It loads the outgoing bytes through a byte-wide data port and then sets a go bit. The controller lowers chip select and shifts out the command byte. It then sends the queued bytes and keeps clocking until every reply byte has been captured. Only then does it raise chip select again.

Outgoing and incoming bytes live in one eight-entry ring buffer, and the buffer is never wiped. Each byte clocked after the command byte overwrites the buffer slot it came from with the byte sampled from the flash, so the reply follows the sent bytes in the same ring. To read the reply, software rewinds the pointer, steps past the bytes it sent, and then reads. The pointer is visible in a status register, next to a two-bit serial clock rate select.

Top module: `spif_ctrl`

## Requirements
- R1: The command byte is held in its own register at offset 0x0. It reads back unchanged and is always the first byte shifted out, most significant bit first. It is never taken from the ring buffer.
- R2: Offset 0x1 holds the reply count in bits 7:4 and the send count in bits 3:0, where the send count excludes the command byte. The register keeps its value after a transfer completes.
- R3: Writing 1 to bit 0 of offset 0x2 starts a transfer. Bit 0 of offset 0x2 reads 1 while the transfer runs and returns to 0 by itself when it ends.
- R4: Writing 1 to bit 4 of offset 0x2 sets the ring pointer to zero. Bit 4 itself reads as 0.
- R5: Each write or read of the data port at offset 0xC touches the ring slot at the pointer and then moves the pointer on by one. The pointer reads back in bits 2:0 of offset 0xD and wraps from 7 to 0.
- R6: The sent bytes come from the ring, beginning at the pointer. Every byte clocked after the command replaces its ring slot with the byte sampled from the flash. After a transfer the pointer equals start + send count + reply count, modulo 8. Slots not reached keep their contents. All slots read 0 after reset.
- R7: During the reply phase, the data output shifts out all-ones bytes.
- R8: A go request with a send count above 5 or a reply count above 8 is ignored. No transfer starts, chip select stays high and the pointer does not move.
- R9: Bits 5:4 of offset 0xD select the serial clock rate. A value s makes each low phase and each high phase of the serial clock last s+1 base clock cycles.
- R10: Chip select is low for the whole command, send and reply sequence and is high otherwise. The number of serial clock pulses is 8 × (1 + send + reply), including for a command with no bytes to send.
- R11: The serial clock idles low. The data output changes only while the serial clock is low, and the input is sampled as the serial clock rises.
- R12: While a transfer runs, writes to the command, count, data and rate registers are ignored, and so are pointer clears. Data-port reads while a transfer runs do not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register offset of the current access |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; a data-port read advances the pointer at the clock edge |
| rd_data | output | 8 | Combinational read data for `addr` |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The assertions take for granted that the register bus makes at most one access per cycle and that its inputs, together with the flash data input, are settled at each rising base clock edge. They also assume the rate select cannot change during a transfer, a condition the block enforces itself. The bench drives every access on the falling base clock edge and holds it for one full cycle. Its flash model changes the returned bit only just after a serial clock rise, so the sample taken at the next rise always sees a settled value.

// File: rtl/spif_pkg.sv
package spif_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_OPCODE = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_COUNT  = 4'h1;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 4'h2;
  localparam logic [ADDR_W-1:0] OFS_DATA   = 4'hC;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 4'hD;

  localparam int CTRL_GO_BIT  = 0;
  localparam int CTRL_CLR_BIT = 4;
  localparam int STAT_SEL_LSB = 4;

  typedef enum logic {
    ENG_IDLE  = 1'b0,
    ENG_SHIFT = 1'b1
  } eng_state_e;
endpackage

// File: rtl/spif_clkdiv.sv
module spif_clkdiv #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] sel,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == sel);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (sel != '0)) |=> !tick); // R9
endmodule

// File: rtl/spif_ring.sv
module spif_ring #(
  parameter int DEPTH  = 8,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     host_we,
  input  logic                     host_adv,
  input  logic [BYTE_W-1:0]        host_wdata,
  input  logic                     eng_we,
  input  logic [BYTE_W-1:0]        eng_wdata,
  output logic [$clog2(DEPTH)-1:0] ptr,
  output logic [BYTE_W-1:0]        rdata
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic [BYTE_W-1:0] mem_q [DEPTH];
  logic [BYTE_W-1:0] wdata;
  logic              any_we;
  logic              step;

  assign any_we = host_we | eng_we;
  assign wdata  = eng_we ? eng_wdata : host_wdata;
  assign step   = host_adv | eng_we;

  always_comb begin
    if (clr)       ptr_d = '0;
    else if (step) ptr_d = ptr_q + 1'b1;
    else           ptr_d = ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic slot_en;
    assign slot_en = any_we && (ptr_q == PTR_W'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem_q[gi] <= '0;
      else if (slot_en) mem_q[gi] <= wdata;
    end
  end

  assign ptr   = ptr_q;
  assign rdata = mem_q[ptr_q];

  AST_SINGLE_MOVER: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_adv && eng_we)); // R12
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((ptr_q == $past(ptr_q)) || (ptr_q == PTR_W'($past(ptr_q) + 1'b1)))); // R5
endmodule

// File: rtl/spif_engine.sv
module spif_engine
  import spif_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] opcode,
  input  logic [CNT_W-1:0]  tx_cnt,
  input  logic [CNT_W-1:0]  rx_cnt,
  input  logic              tick,
  input  logic [BYTE_W-1:0] ring_rdata,
  input  logic              miso,
  output logic              busy,
  output logic              sck,
  output logic              cs_n,
  output logic              mosi,
  output logic              ring_we,
  output logic [BYTE_W-1:0] ring_wdata
);
  localparam int TOT_W = CNT_W + 1;
  localparam int BIT_W = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);
  localparam logic [TOT_W-1:0] ONE_B    = TOT_W'(1);

  eng_state_e        state_q, state_d;
  logic              sck_q, sck_d;
  logic              cs_n_q, cs_n_d;
  logic [BYTE_W-1:0] tx_sr_q, tx_sr_d;
  logic [BYTE_W-1:0] rx_sr_q, rx_sr_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [TOT_W-1:0]  byte_q, byte_d;
  logic [CNT_W-1:0]  txn_q, txn_d;
  logic [TOT_W-1:0]  tot_q, tot_d;
  logic [TOT_W-1:0]  byte_nx;
  logic [BYTE_W-1:0] rx_shift;

  assign byte_nx    = byte_q + ONE_B;
  assign rx_shift   = {rx_sr_q[BYTE_W-2:0], miso};
  assign ring_wdata = rx_shift;

  always_comb begin
    state_d = state_q;
    sck_d   = sck_q;
    cs_n_d  = cs_n_q;
    tx_sr_d = tx_sr_q;
    rx_sr_d = rx_sr_q;
    bit_d   = bit_q;
    byte_d  = byte_q;
    txn_d   = txn_q;
    tot_d   = tot_q;
    ring_we = 1'b0;
    case (state_q)
      ENG_IDLE: begin
        if (start) begin
          state_d = ENG_SHIFT;
          cs_n_d  = 1'b0;
          sck_d   = 1'b0;
          tx_sr_d = opcode;
          bit_d   = '0;
          byte_d  = '0;
          txn_d   = tx_cnt;
          tot_d   = TOT_W'(tx_cnt) + TOT_W'(rx_cnt);
        end
      end
      ENG_SHIFT: begin
        if (tick) begin
          if (!sck_q) begin
            // rising edge: capture one input bit
            sck_d   = 1'b1;
            rx_sr_d = rx_shift;
            ring_we = (bit_q == LAST_BIT) && (byte_q != '0);
          end else begin
            // falling edge: present the next output bit
            sck_d = 1'b0;
            if (bit_q == LAST_BIT) begin
              if (byte_q == tot_q) begin
                state_d = ENG_IDLE;
                cs_n_d  = 1'b1;
              end else begin
                byte_d  = byte_nx;
                bit_d   = '0;
                tx_sr_d = (byte_nx <= {1'b0, txn_q}) ? ring_rdata : '1;
              end
            end else begin
              bit_d   = bit_q + 1'b1;
              tx_sr_d = {tx_sr_q[BYTE_W-2:0], 1'b0};
            end
          end
        end
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      sck_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      tx_sr_q <= '0;
      rx_sr_q <= '0;
      bit_q   <= '0;
      byte_q  <= '0;
      txn_q   <= '0;
      tot_q   <= '0;
    end else begin
      state_q <= state_d;
      sck_q   <= sck_d;
      cs_n_q  <= cs_n_d;
      tx_sr_q <= tx_sr_d;
      rx_sr_q <= rx_sr_d;
      bit_q   <= bit_d;
      byte_q  <= byte_d;
      txn_q   <= txn_d;
      tot_q   <= tot_d;
    end
  end

  assign busy = (state_q == ENG_SHIFT);
  assign sck  = sck_q;
  assign cs_n = cs_n_q;
  assign mosi = busy ? tx_sr_q[BYTE_W-1] : 1'b0;

  AST_CS_DURING_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cs_n); // R10
  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck); // R11
  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_q && $past(sck_q)) |-> $stable(mosi)); // R11
endmodule

// File: rtl/spif_ctrl.sv
module spif_ctrl
  import spif_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int BYTE_W     = 8,
  parameter int CNT_W      = 4,
  parameter int DIV_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        addr,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rd_data,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int PTR_W  = $clog2(FIFO_DEPTH);
  localparam int TX_MAX = FIFO_DEPTH - 3;
  localparam int RX_MAX = FIFO_DEPTH;

  logic [BYTE_W-1:0]  op_q;
  logic [2*CNT_W-1:0] cnt_q;
  logic [DIV_W-1:0]   sel_q;
  logic [CNT_W-1:0]   tx_cnt, rx_cnt;
  logic               busy;
  logic               legal;
  logic               wr_op, wr_cnt, wr_ctrl, wr_sel;
  logic               go, clr, host_we, host_adv;
  logic               tick;
  logic               eng_we;
  logic [BYTE_W-1:0]  eng_wdata;
  logic [BYTE_W-1:0]  ring_rdata;
  logic [PTR_W-1:0]   ptr;
  logic [BYTE_W-1:0]  stat_word;

  assign tx_cnt = cnt_q[CNT_W-1:0];
  assign rx_cnt = cnt_q[2*CNT_W-1:CNT_W];
  assign legal  = (int'(tx_cnt) <= TX_MAX) && (int'(rx_cnt) <= RX_MAX);

  // register strobes, all blocked while a transfer runs
  assign wr_op    = wr_en && !busy && (addr == OFS_OPCODE);
  assign wr_cnt   = wr_en && !busy && (addr == OFS_COUNT);
  assign wr_ctrl  = wr_en && !busy && (addr == OFS_CTRL);
  assign wr_sel   = wr_en && !busy && (addr == OFS_STAT);
  assign host_we  = wr_en && !busy && (addr == OFS_DATA);
  assign host_adv = host_we || (rd_en && !busy && (addr == OFS_DATA));
  assign go       = wr_ctrl && wr_data[CTRL_GO_BIT] && legal;
  assign clr      = wr_ctrl && wr_data[CTRL_CLR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     op_q <= '0;
    else if (wr_op) op_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wr_cnt) cnt_q <= wr_data[2*CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (wr_sel) sel_q <= wr_data[STAT_SEL_LSB+DIV_W-1:STAT_SEL_LSB];
  end

  spif_clkdiv #(.DIV_W(DIV_W)) u_clkdiv (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .sel  (sel_q),
    .tick (tick)
  );

  spif_ring #(.DEPTH(FIFO_DEPTH), .BYTE_W(BYTE_W)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .host_we   (host_we),
    .host_adv  (host_adv),
    .host_wdata(wr_data),
    .eng_we    (eng_we),
    .eng_wdata (eng_wdata),
    .ptr       (ptr),
    .rdata     (ring_rdata)
  );

  spif_engine #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (go),
    .opcode    (op_q),
    .tx_cnt    (tx_cnt),
    .rx_cnt    (rx_cnt),
    .tick      (tick),
    .ring_rdata(ring_rdata),
    .miso      (spi_miso),
    .busy      (busy),
    .sck       (spi_sck),
    .cs_n      (spi_cs_n),
    .mosi      (spi_mosi),
    .ring_we   (eng_we),
    .ring_wdata(eng_wdata)
  );

  always_comb begin
    stat_word = '0;
    stat_word[PTR_W-1:0] = ptr;
    stat_word[STAT_SEL_LSB+DIV_W-1:STAT_SEL_LSB] = sel_q;
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      OFS_OPCODE: rd_data = op_q;
      OFS_COUNT:  rd_data = cnt_q;
      OFS_CTRL:   rd_data[CTRL_GO_BIT] = busy;
      OFS_DATA:   rd_data = ring_rdata;
      OFS_STAT:   rd_data = stat_word;
      default:    rd_data = '0;
    endcase
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(op_q) && $stable(cnt_q) && $stable(sel_q))); // R12
  AST_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(go)) |-> spi_cs_n); // R10
endmodule

// File: tb/spif_ctrl_bench.sv
module spif_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       spi_sck, spi_cs_n, spi_mosi, spi_miso;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spif_ctrl u_spif_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // flash model
  logic [7:0] resp_mem [16];
  logic [7:0] cap_mem  [16];
  logic [7:0] ref_ring [8];
  int  bit_cnt = 0;
  int  gap_err = 0;
  time exp_gap = 0;
  time last_rise = 0;
  bit  first_rise = 1'b1;

  assign spi_miso = (bit_cnt < 128) ? resp_mem[bit_cnt / 8][7 - (bit_cnt % 8)] : 1'b0;

  always @(negedge spi_cs_n) begin
    bit_cnt    = 0;
    first_rise = 1'b1;
  end

  always @(posedge spi_sck) begin
    if (!spi_cs_n && bit_cnt < 128) begin
      cap_mem[bit_cnt / 8] = {cap_mem[bit_cnt / 8][6:0], spi_mosi};
      if (!first_rise && (($time - last_rise) != exp_gap)) gap_err++;
      first_rise = 1'b0;
      last_rise  = $time;
      bit_cnt++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1;
    d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic check_ring(input string req);
    logic [7:0] v;
    wr(4'h2, 8'h10);
    for (int i = 0; i < 8; i++) begin
      rd(4'hC, v);
      chk(req, v, ref_ring[i]);
    end
  endtask

  task automatic run_txn(input logic [7:0] op, input int tx, input int rx,
                         input int sel, input bit poke);
    logic [7:0] v;
    logic [7:0] txd [8];
    int guard;
    wr(4'hD, 8'(sel << 4));
    wr(4'h0, op);
    wr(4'h1, {4'(rx), 4'(tx)});
    wr(4'h2, 8'h10);
    rd(4'hD, v);
    chk("R4 pointer cleared", v[2:0], 0);
    for (int i = 0; i < tx; i++) begin
      txd[i] = 8'($urandom);
      wr(4'hC, txd[i]);
      ref_ring[i] = txd[i];
    end
    rd(4'hD, v);
    chk("R5 pointer after fill", v[2:0], tx % 8);
    for (int k = 0; k < 16; k++) begin
      resp_mem[k] = 8'($urandom);
      cap_mem[k]  = 8'h00;
    end
    gap_err = 0;
    exp_gap = 2 * (sel + 1) * CLK_PERIOD;
    wr(4'h2, 8'h10);
    wr(4'h2, 8'h01);
    rd(4'h2, v);
    chk("R3 busy set after go", v[0], 1);
    chk("R10 chip select low while busy", spi_cs_n, 0);
    if (poke) begin
      wr(4'h0, ~op);
      wr(4'h1, 8'h00);
      wr(4'hC, 8'hA5);
      wr(4'hD, 8'h00);
      wr(4'h2, 8'h10);
      rd(4'hC, v);
      rd(4'h2, v);
      chk("R12 still busy after pokes", v[0], 1);
    end
    guard = 0;
    do begin
      rd(4'h2, v);
      guard++;
    end while (v[0] && guard < 5000);
    chk("R3 busy clears", v[0], 0);
    chk("R10 chip select high after", spi_cs_n, 1);
    chk("R11 clock idles low", spi_sck, 0);
    chk("R9 serial clock period", gap_err, 0);
    chk("R10 pulse count", bit_cnt, 8 * (1 + tx + rx));
    chk("R1 command byte first", cap_mem[0], op);
    for (int j = 1; j <= tx; j++) chk("R6 sent byte from ring", cap_mem[j], txd[j-1]);
    for (int j = tx + 1; j <= tx + rx; j++) chk("R7 reply phase ones", cap_mem[j], 8'hFF);
    for (int k = 1; k <= tx + rx; k++) ref_ring[(k - 1) % 8] = resp_mem[k];
    rd(4'hD, v);
    chk("R6 pointer after transfer", v[2:0], (tx + rx) % 8);
    chk("R9 rate select readback", v[5:4], sel);
    rd(4'h1, v);
    chk("R2 count retained", v, {4'(rx), 4'(tx)});
    rd(4'h0, v);
    chk("R1 command readback", v, op);
    check_ring("R6 ring contents");
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) ref_ring[i] = 8'h00;
    for (int k = 0; k < 16; k++) resp_mem[k] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // reset state
    rd(4'h0, v); chk("R1 reset command", v, 0);
    rd(4'h1, v); chk("R2 reset count", v, 0);
    rd(4'h2, v); chk("R3 reset idle", v, 0);
    rd(4'hD, v); chk("R5 reset status", v, 0);
    chk("R10 reset chip select", spi_cs_n, 1);
    chk("R11 reset clock", spi_sck, 0);
    check_ring("R6 reset ring");

    // pointer wrap through the data port
    wr(4'h2, 8'h10);
    for (int i = 0; i < 10; i++) wr(4'hC, 8'(8'h40 + i));
    rd(4'hD, v); chk("R5 pointer wraps", v[2:0], 2);
    for (int i = 0; i < 8; i++) ref_ring[i] = 8'(8'h40 + i);
    ref_ring[0] = 8'h48; ref_ring[1] = 8'h49;
    check_ring("R5 wrap overwrite");

    // illegal counts
    wr(4'h2, 8'h10);
    wr(4'hC, 8'h11);
    wr(4'h1, 8'h06);
    wr(4'h2, 8'h01);
    rd(4'h2, v); chk("R8 send count 6 refused", v[0], 0);
    chk("R8 chip select stays high", spi_cs_n, 1);
    rd(4'hD, v); chk("R8 pointer unmoved", v[2:0], 1);
    wr(4'h1, 8'h90);
    wr(4'h2, 8'h01);
    rd(4'h2, v); chk("R8 reply count 9 refused", v[0], 0);
    rd(4'hD, v); chk("R8 pointer unmoved again", v[2:0], 1);
    ref_ring[0] = 8'h11;

    // directed corners
    run_txn(8'h9F, 0, 3, 0, 1'b0);  // R10 command only with reply
    run_txn(8'h02, 5, 8, 1, 1'b0);  // largest legal counts, wraps
    run_txn(8'h06, 0, 0, 2, 1'b0);  // bare command
    run_txn(8'h0B, 2, 4, 3, 1'b1);  // R12 pokes while busy

    // constrained random
    for (int n = 0; n < 24; n++) begin
      run_txn(8'($urandom), int'($urandom_range(5, 0)), int'($urandom_range(8, 0)),
              int'($urandom_range(3, 0)), (n % 6) == 5);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule